// File: doc/BRIEF.md
# I2C Slave Byte Engine with Selectable Clock Stretch Point

This block is the receive and transmit engine of an I2C target. It watches SCL and SDA through a synchroniser. It finds start and stop conditions and counts SCL clocks within each byte. It compares the first byte after a start with a 7-bit own address held on an input port. After a match it shifts data bytes in (write transfers) or out (read transfers). The block drives the open-drain pads only through two pull-low enables, one for SCL and one for SDA.

At one chosen SCL falling edge of every byte, the engine holds SCL low and raises a one-cycle interrupt pulse. Software handles the byte and then frees the bus with a one-cycle release pulse. For data bytes, a control input selects whether this stop point is the eighth or the ninth falling edge. Address bytes follow fixed rules: a normal matching address stops at the ninth edge, after its acknowledge. An extension-code address stops at the eighth edge. The remaining control inputs set acknowledge behaviour for received data, enable an interrupt on a stop condition, and enable or disable the whole engine.

The block is a target only. It does not generate a clock, arbitrate, time out, or complete 10-bit addressing.

Top module: `i2c_slave_stretch`

## Requirements
- R1: After reset, `scl_pull`, `sda_pull` and `irq` are 0, `rx_byte` is 0x00, and all three outputs stay 0 while the bus is idle.
- R2: For an address byte whose upper five bits are not 11110, SDA is pulled low during the ninth clock exactly when bits 7..1 equal `own_addr`, whatever `ack_en` is. A non-matching address gets no acknowledge, no stretch and no `irq` for the rest of that transfer.
- R3: A matching address pulls SCL low and pulses `irq` at the ninth SCL falling edge and not at the eighth, whatever `wait_ninth` is.
- R4: An extension-code address (upper five bits 11110) pulls SCL low and pulses `irq` at the eighth falling edge and not at the ninth. It is acknowledged exactly when `ack_en` is 1.
- R5: For data bytes, with `wait_ninth`=0 the stretch and `irq` occur at the eighth falling edge only. With `wait_ninth`=1 they occur at the ninth falling edge only. Whenever SCL starts being held, `irq` pulses in that same cycle.
- R6: A received data byte (MSB first) appears on `rx_byte` after its eighth falling edge. SDA is pulled low through the ninth clock exactly when `ack_en` is 1. `sda_pull` only changes while SCL is low.
- R7: A stop condition (SDA rising while SCL is high) pulses `irq` exactly when `stop_irq_en` is 1.
- R8: While `en` is 0, the block pulls neither line, acknowledges nothing and raises no `irq`, whatever the other control inputs are.
- R9: After a matching address with bit 0 of the address byte set to 1 (read), the block sends the last byte given by `tx_load` before the stretch is released, MSB first. A master ACK on the ninth clock leads to the next byte. A master NACK leaves SDA released and stops all stretching until the next start.
- R10: A stretch holds SCL low for any length of time until `rel_pulse` is seen. SCL is then free from the next clock onward.
- R11: A start condition at any bit position abandons the current byte, so that the following byte is received as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable; 0 holds the engine idle |
| wait_ninth | input | 1 | Data-byte stop point: 0 = eighth falling edge, 1 = ninth |
| ack_en | input | 1 | Acknowledge received data bytes and extension-code addresses |
| stop_irq_en | input | 1 | Raise `irq` on a stop condition |
| own_addr | input | 7 | Own 7-bit target address |
| rel_pulse | input | 1 | One-cycle pulse ending a stretch |
| tx_load | input | 1 | Load `tx_byte` as the next byte to transmit |
| tx_byte | input | 8 | Byte to transmit in read transfers |
| scl_in | input | 1 | SCL pad level |
| sda_in | input | 1 | SDA pad level |
| scl_pull | output | 1 | Pull SCL low (stretch) |
| sda_pull | output | 1 | Pull SDA low |
| irq | output | 1 | One-cycle interrupt pulse |
| rx_byte | output | 8 | Last received data byte |

## Verification
The bench builds the block with its default two-stage synchroniser and own address 0x2A. It clocks the bus at roughly twenty system clocks per SCL period, so every synchroniser delay and every stretch falls well inside one SCL phase. With both `ack_en` settings, it sweeps all 128 seven-bit addresses in write direction and alternates `wait_ninth` between them. This covers every extension code, every non-matching address and the matching one, and checks acknowledge and stop point against values computed from the address bits. Data reception runs over all four combinations of `wait_ninth` and `ack_en` with several byte patterns. Read transfers with ACK and with NACK, a disabled engine, and a repeated start inside an address byte complete the set.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_BITS = 8;
    localparam int ADDR_BITS = 7;
    localparam int CNT_W     = $clog2(BYTE_BITS + 2);
    localparam logic [4:0] EXT_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_TX,
        ST_SKIP
    } eng_state_e;

    typedef struct packed {
        logic en;
        logic wait9;
        logic ack_en;
        logic stop_ie;
    } ctl_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic is_ext_code(input logic [ADDR_BITS-1:0] a);
        return a[ADDR_BITS-1 -: 5] == EXT_PREFIX;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[CHAIN_W-W-1:0], d};
    end

    assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  ctl_t                 ctl,
    input  logic [ADDR_BITS-1:0] own_addr,
    input  logic                 rel_pulse,
    input  logic                 tx_load,
    input  logic [BYTE_BITS-1:0] tx_byte,
    input  bus_ev_t              ev,
    output logic                 scl_pull,
    output logic                 sda_pull,
    output logic                 irq,
    output logic [BYTE_BITS-1:0] rx_byte
);
    localparam logic [CNT_W-1:0] EDGE_LAST = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] EDGE_ACK  = CNT_W'(BYTE_BITS + 1);

    eng_state_e           state;
    logic [CNT_W-1:0]     cnt;
    logic [BYTE_BITS-1:0] sh_in, tx_sr, tx_buf;
    logic                 stretch, ack_drv, tx_drv, ext_r, rw_r, nack_r;
    logic                 active;

    assign active = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf  <= '0;
            rx_byte <= '0;
        end else begin
            if (tx_load) tx_buf <= tx_byte;
            if (ctl.en && !ev.start && !ev.stop && ev.fall && cnt == EDGE_LAST
                && state == ST_RX)
                rx_byte <= sh_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !ctl.en) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sh_in   <= '0;
            tx_sr   <= '1;
            stretch <= 1'b0;
            ack_drv <= 1'b0;
            tx_drv  <= 1'b0;
            ext_r   <= 1'b0;
            rw_r    <= 1'b0;
            nack_r  <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (ev.start || ev.stop) begin
                state   <= ev.start ? ST_ADDR : ST_IDLE;
                cnt     <= '0;
                stretch <= 1'b0;
                ack_drv <= 1'b0;
                tx_drv  <= 1'b0;
                ext_r   <= 1'b0;
                irq     <= ev.stop & ctl.stop_ie;
            end else begin
                if (rel_pulse && stretch) begin
                    stretch <= 1'b0;
                    if (state == ST_TX && cnt == '0) tx_sr <= tx_buf;
                end
                if (ev.rise && active) begin
                    cnt <= cnt + 1'b1;
                    if (cnt < EDGE_LAST) sh_in <= {sh_in[BYTE_BITS-2:0], ev.sda};
                    if (cnt == EDGE_LAST) nack_r <= ev.sda;
                end
                if (ev.fall && active) begin
                    if (cnt == EDGE_LAST) begin
                        unique case (state)
                            ST_ADDR: begin
                                if (is_ext_code(sh_in[BYTE_BITS-1:1])) begin
                                    ext_r   <= 1'b1;
                                    ack_drv <= ctl.ack_en;
                                    stretch <= 1'b1;
                                    irq     <= 1'b1;
                                end else if (sh_in[BYTE_BITS-1:1] == own_addr) begin
                                    ack_drv <= 1'b1;
                                    rw_r    <= sh_in[0];
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end
                            ST_RX: begin
                                ack_drv <= ctl.ack_en;
                                if (!ctl.wait9) begin
                                    stretch <= 1'b1;
                                    irq     <= 1'b1;
                                end
                            end
                            ST_TX: begin
                                tx_drv <= 1'b0;
                                if (!ctl.wait9) begin
                                    stretch <= 1'b1;
                                    irq     <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end else if (cnt == EDGE_ACK) begin
                        cnt     <= '0;
                        ack_drv <= 1'b0;
                        unique case (state)
                            ST_ADDR: begin
                                if (ext_r) begin
                                    state <= ST_RX;
                                end else begin
                                    stretch <= 1'b1;
                                    irq     <= 1'b1;
                                    if (rw_r) begin
                                        state  <= ST_TX;
                                        tx_sr  <= tx_buf;
                                        tx_drv <= 1'b1;
                                    end else begin
                                        state <= ST_RX;
                                    end
                                end
                            end
                            ST_RX: begin
                                if (ctl.wait9) begin
                                    stretch <= 1'b1;
                                    irq     <= 1'b1;
                                end
                            end
                            ST_TX: begin
                                if (ctl.wait9) begin
                                    stretch <= 1'b1;
                                    irq     <= 1'b1;
                                end
                                if (nack_r) begin
                                    state <= ST_SKIP;
                                end else begin
                                    tx_sr  <= tx_buf;
                                    tx_drv <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end else if (cnt != '0 && state == ST_TX && tx_drv) begin
                        tx_sr <= {tx_sr[BYTE_BITS-2:0], 1'b1};
                    end
                end
            end
        end
    end

    assign scl_pull = stretch;
    assign sda_pull = ack_drv | (tx_drv & ~tx_sr[BYTE_BITS-1]);
endmodule

// File: rtl/i2c_slave_stretch.sv
module i2c_slave_stretch
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       wait_ninth,
    input  logic       ack_en,
    input  logic       stop_irq_en,
    input  logic [6:0] own_addr,
    input  logic       rel_pulse,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull,
    output logic       irq,
    output logic [7:0] rx_byte
);
    logic [1:0] lines_s;
    bus_ev_t    ev;
    ctl_t       ctl;

    assign ctl = '{en: en, wait9: wait_ninth, ack_en: ack_en, stop_ie: stop_irq_en};

    i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (lines_s)
    );

    i2cs_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .ev    (ev)
    );

    i2cs_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .own_addr  (own_addr),
        .rel_pulse (rel_pulse),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .ev        (ev),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .irq       (irq),
        .rx_byte   (rx_byte)
    );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic rel_pulse,
    input logic scl_in,
    input logic scl_pull,
    input logic sda_pull,
    input logic irq
);
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!scl_pull && !sda_pull && !irq)) else $error("disabled engine active"); // R8

    AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (en && scl_pull && !rel_pulse) |=> scl_pull) else $error("stretch dropped early"); // R10

    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (rst)
        (en && scl_pull && rel_pulse) |=> !scl_pull) else $error("release ignored"); // R10

    AST_STRETCH_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_pull) |-> irq) else $error("stretch without irq"); // R5

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$stable(sda_pull)) |-> !scl_in) else $error("sda moved with scl high"); // R6
endmodule

bind i2c_slave_stretch i2cs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .rel_pulse (rel_pulse),
    .scl_in    (scl_in),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .irq       (irq)
);

// File: tb/test_i2c_slave_stretch.sv
module test_i2c_slave_stretch;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, wait_ninth = 1'b0, ack_en = 1'b0, stop_irq_en = 1'b0;
    logic rel_pulse = 1'b0, tx_load = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_in, sda_in, scl_pull, sda_pull, irq;
    logic [7:0] rx_byte;

    int checks = 0, failures = 0, irq_cnt = 0;
    logic       tx_pend = 1'b0;
    logic [7:0] tx_next = 8'h00;

    always #5 clk = ~clk;

    assign scl_in = scl_m & ~scl_pull;
    assign sda_in = sda_m & ~sda_pull;

    always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

    i2c_slave_stretch #(.SYNC_STAGES(2)) i_i2c_slave_stretch (
        .clk(clk), .rst(rst), .en(en), .wait_ninth(wait_ninth), .ack_en(ack_en),
        .stop_irq_en(stop_irq_en), .own_addr(OWN), .rel_pulse(rel_pulse),
        .tx_load(tx_load), .tx_byte(tx_byte), .scl_in(scl_in), .sda_in(sda_in),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .irq(irq), .rx_byte(rx_byte)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_release();
        wait_clk(20);
        chk(scl_pull == 1'b1, "R10 held", int'(scl_pull), 1);
        if (tx_pend) begin
            tx_byte = tx_next; tx_load = 1'b1; wait_clk(1); tx_load = 1'b0; tx_pend = 1'b0;
        end
        rel_pulse = 1'b1; wait_clk(1); rel_pulse = 1'b0;
        chk(scl_pull == 1'b0, "R10 freed", int'(scl_pull), 0);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_m = b;
        wait_clk(3);
        scl_m = 1'b1;
        while (!scl_in) wait_clk(1);
        wait_clk(2);
        seen = sda_in;
        wait_clk(2);
        scl_m = 1'b0;
        wait_clk(7);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(3);
        scl_m = 1'b1;
        while (!scl_in) wait_clk(1);
        wait_clk(4); sda_m = 1'b0; wait_clk(5); scl_m = 1'b0; wait_clk(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(3);
        scl_m = 1'b1;
        while (!scl_in) wait_clk(1);
        wait_clk(4); sda_m = 1'b1; wait_clk(8);
    endtask

    // two-bit code per falling edge: {irq seen, stretch seen}
    task automatic send_byte(input logic [7:0] b, output logic ack,
                             output logic [1:0] e8, output logic [1:0] e9);
        logic s;
        int c0;
        for (int i = 7; i >= 1; i--) clock_bit(b[i], s);
        c0 = irq_cnt;
        clock_bit(b[0], s);
        e8 = {irq_cnt != c0, scl_pull};
        if (scl_pull) do_release();
        c0 = irq_cnt;
        clock_bit(1'b1, s);
        ack = ~s;
        e9 = {irq_cnt != c0, scl_pull};
        if (scl_pull) do_release();
    endtask

    task automatic read_byte(input logic m_ack, output logic [7:0] d,
                             output logic [1:0] e8, output logic [1:0] e9);
        logic s;
        int c0;
        for (int i = 7; i >= 1; i--) begin clock_bit(1'b1, s); d[i] = s; end
        c0 = irq_cnt;
        clock_bit(1'b1, s); d[0] = s;
        e8 = {irq_cnt != c0, scl_pull};
        if (scl_pull) do_release();
        c0 = irq_cnt;
        clock_bit(~m_ack, s);
        e9 = {irq_cnt != c0, scl_pull};
        if (scl_pull) do_release();
        wait_clk(1);
        sda_m = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        logic ack, s;
        logic [1:0] e8, e9;
        logic [7:0] d;
        logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81};
        int c0;

        wait_clk(4);
        rst = 1'b0;
        wait_clk(10);
        // R1: idle outputs after reset
        chk({scl_pull, sda_pull, irq} == 3'b000, "R1 pulls", int'({scl_pull, sda_pull, irq}), 0);
        chk(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
        en = 1'b1;
        wait_clk(20);
        chk({scl_pull, sda_pull} == 2'b00 && irq_cnt == 0, "R1 idle enabled", irq_cnt, 0);

        // R2/R3/R4: every 7-bit address, both ack_en settings
        for (int ae = 0; ae < 2; ae++) begin
            for (int a = 0; a < 128; a++) begin
                logic [6:0] ad;
                logic is_ext, is_own;
                ad = 7'(a);
                ack_en = ae[0];
                wait_ninth = ad[0];
                is_ext = (ad[6:2] == 5'b11110);
                is_own = !is_ext && (ad == OWN);
                bus_start();
                send_byte({ad, 1'b0}, ack, e8, e9);
                bus_stop();
                if (is_ext) begin
                    chk(ack == ae[0], "R4 ext ack", int'(ack), ae);
                    chk(e8 == 2'b11, "R4 ext stop at 8th", int'(e8), 3);
                    chk(e9 == 2'b00, "R4 ext none at 9th", int'(e9), 0);
                end else if (is_own) begin
                    chk(ack == 1'b1, "R2 match ack", int'(ack), 1);
                    chk(e8 == 2'b00, "R3 none at 8th", int'(e8), 0);
                    chk(e9 == 2'b11, "R3 stop at 9th", int'(e9), 3);
                end else begin
                    chk(ack == 1'b0, "R2 mismatch ack", int'(ack), 0);
                    chk(e8 == 2'b00 && e9 == 2'b00, "R2 mismatch quiet", int'({e8, e9}), 0);
                end
            end
        end

        // R5/R6/R7: data reception
        for (int w = 0; w < 2; w++) begin
            for (int ae = 0; ae < 2; ae++) begin
                for (int k = 0; k < 5; k++) begin
                    wait_ninth = w[0];
                    ack_en = ae[0];
                    stop_irq_en = w[0] ^ ae[0];
                    bus_start();
                    send_byte({OWN, 1'b0}, ack, e8, e9);
                    chk(ack == 1'b1, "R2 addr ack", int'(ack), 1);
                    for (int r = 0; r < 2; r++) begin
                        logic [7:0] dv;
                        dv = (r == 0) ? pats[k] : ~pats[k];
                        send_byte(dv, ack, e8, e9);
                        chk(e8 == (w[0] ? 2'b00 : 2'b11), "R5 8th edge", int'(e8), w[0] ? 0 : 3);
                        chk(e9 == (w[0] ? 2'b11 : 2'b00), "R5 9th edge", int'(e9), w[0] ? 3 : 0);
                        chk(ack == ae[0], "R6 data ack", int'(ack), ae);
                        chk(rx_byte == dv, "R6 rx_byte", rx_byte, dv);
                    end
                    c0 = irq_cnt;
                    bus_stop();
                    chk((irq_cnt - c0) == int'(stop_irq_en), "R7 stop irq", irq_cnt - c0, int'(stop_irq_en));
                end
            end
        end
        stop_irq_en = 1'b0;

        // R9: read, wait at ninth edge
        wait_ninth = 1'b1;
        bus_start();
        tx_next = 8'hA5; tx_pend = 1'b1;
        send_byte({OWN, 1'b1}, ack, e8, e9);
        chk(ack == 1'b1 && e9 == 2'b11, "R9 read addr", int'({ack, e9}), 7);
        tx_next = 8'h3C; tx_pend = 1'b1;
        read_byte(1'b1, d, e8, e9);
        chk(d == 8'hA5, "R9 first byte", d, 8'hA5);
        chk(e8 == 2'b00 && e9 == 2'b11, "R9 wait9 edges", int'({e8, e9}), 3);
        read_byte(1'b0, d, e8, e9);
        chk(d == 8'h3C, "R9 second byte", d, 8'h3C);
        read_byte(1'b1, d, e8, e9);
        chk(d == 8'hFF, "R9 released after nack", d, 8'hFF);
        chk(e8 == 2'b00 && e9 == 2'b00, "R9 no stretch after nack", int'({e8, e9}), 0);
        bus_stop();

        // R9: read, wait at eighth edge
        wait_ninth = 1'b0;
        bus_start();
        tx_next = 8'h96; tx_pend = 1'b1;
        send_byte({OWN, 1'b1}, ack, e8, e9);
        chk(e9 == 2'b11, "R3 read addr 9th", int'(e9), 3);
        tx_next = 8'h4B; tx_pend = 1'b1;
        read_byte(1'b1, d, e8, e9);
        chk(d == 8'h96 && e8 == 2'b11, "R9 wait8 first", int'({d, e8}), int'({8'h96, 2'b11}));
        read_byte(1'b0, d, e8, e9);
        chk(d == 8'h4B, "R9 wait8 second", d, 8'h4B);
        bus_stop();

        // R11: repeated start in the middle of an address byte
        wait_ninth = 1'b0;
        bus_start();
        clock_bit(1'b1, s); clock_bit(1'b0, s); clock_bit(1'b1, s); clock_bit(1'b1, s);
        bus_start();
        send_byte({OWN, 1'b0}, ack, e8, e9);
        chk(ack == 1'b1 && e8 == 2'b00 && e9 == 2'b11, "R11 restart", int'({ack, e8, e9}), 19);
        bus_stop();

        // R8: disabled engine
        en = 1'b0; stop_irq_en = 1'b1; ack_en = 1'b1;
        c0 = irq_cnt;
        bus_start();
        send_byte({OWN, 1'b0}, ack, e8, e9);
        chk(ack == 1'b0 && e8 == 2'b00 && e9 == 2'b00, "R8 no response", int'({ack, e8, e9}), 0);
        bus_stop();
        chk(irq_cnt == c0 && !scl_pull && !sda_pull, "R8 no irq", irq_cnt - c0, 0);

        finish_run();
    end
endmodule